// File: doc/BRIEF.md
# EPROM Pulse-Verify Programming Sequencer

This block sits inside a device programmer and writes a byte image into an ultraviolet-erasable EPROM of 8-bit words. It walks the address range from zero upwards. At each address it fetches the target byte from an image port. It places that byte on the memory's data pins and applies a program pulse of fixed length. It then releases the bus, reads the location back and compares the result. The pulse is repeated only as often as the location needs. The loop stops when the byte matches, when the read-back shows a bit that can no longer be set back to one, or when a per-address pulse limit is reached.

Each programming step runs with the programming-voltage select and the raised core-supply select both asserted. After the last address the sequencer switches those selects off and asserts the nominal verify-rail select. It then reads the whole array once more and compares every location against the image. A single `start` strobe begins a run. A single-cycle `done` pulse marks its end. Two sticky flags, each with the first failing address, report a programming failure and a final-verify failure. Generating the supply voltages themselves belongs to circuitry outside this block.

Top module: `eprom_prog_seq`

## Requirements
- R1: Each program pulse holds `ep_pgm_n` low for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 consecutive clocks.
- R2: While `ep_pgm_n` is low, `ep_ce_n` is low, `ep_oe_n` is high, `vpp_prog_sel` and `vcc_boost_sel` are high, and the sequencer drives the image byte of the current address onto `ep_dq`.
- R3: After every pulse the location is read back with `ep_ce_n` and `ep_oe_n` low, `ep_pgm_n` high, `vpp_prog_sel` still high and `ep_dq` not driven by the sequencer.
- R4: A location that does not yet match gets another pulse. A location that matches after its k-th pulse receives exactly k pulses.
- R5: When a location still mismatches after MAX_PULSES pulses, `prog_fail` is set and `prog_fail_addr` takes that address if no earlier programming failure was recorded. The sequencer then continues with the next address.
- R6: When a read-back shows a 0 in a bit where the target byte has a 1, the location is failed at once under the same flag and address rule as R5, and it receives no further pulse.
- R7: A target byte of all ones (0xFF) receives no pulse.
- R8: `ep_oe_n` is high in the clock before a pulse starts and in the clock after it ends, so that the sequencer and the memory never drive `ep_dq` in adjacent cycles.
- R9: After the last address, every location from 0 to the top is read with `rail_verify_sel` high and `vcc_boost_sel` and `vpp_prog_sel` low. The two rail modes are never asserted together. A mismatch sets `verify_fail`, and `verify_fail_addr` holds the first mismatching address.
- R10: `done` is high for exactly one clock at the end of the verify pass. The flags and addresses hold until the next accepted `start`, which clears them. A run with N locations lasts 1 + 2N + sum of the per-location terms cycles from the start edge to `done`. The per-location term is 2 for a skipped byte and 2 + p*(PULSE_CYC+4) for a byte that got p pulses.
- R11: During reset `ep_ce_n`, `ep_oe_n` and `ep_pgm_n` are high, and `done`, the rail selects and both fail flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only while idle |
| done | output | 1 | One-cycle end-of-run pulse |
| img_addr | output | AW | Address presented to the image store |
| img_data | input | DW | Image byte for `img_addr`, valid in the same cycle |
| ep_addr | output | AW | EPROM address pins |
| ep_dq | inout | DW | EPROM data pins |
| ep_ce_n | output | 1 | EPROM chip enable, active low |
| ep_oe_n | output | 1 | EPROM output enable, active low |
| ep_pgm_n | output | 1 | EPROM program strobe, active low |
| vpp_prog_sel | output | 1 | Selects the programming level on the program-voltage pin |
| vcc_boost_sel | output | 1 | Selects the raised core supply for the per-byte loop |
| rail_verify_sel | output | 1 | Selects the nominal level on both supplies for the final pass |
| prog_fail | output | 1 | Sticky programming failure |
| prog_fail_addr | output | AW | First address that failed programming |
| verify_fail | output | 1 | Sticky final-verify failure |
| verify_fail_addr | output | AW | First address that failed final verify |

## Verification
The bench works on an eight-location array with a ten-clock pulse and a five-pulse limit, and it models the memory. Each location needs a computed number of pulses before its cells take the data. The pulse count the bench expects for a location follows from that need, the limit and the stuck-bit rule, and the run length from `start` to `done` follows from the R10 formula. The bench therefore knows in advance the exact clock at which `done` must rise and checks it there. The memory model samples the pins on every rising edge. It checks the pulse width, the pin levels and the one-cycle gap around each pulse as they happen. Flags, addresses and pulse tallies are read at the falling edge of the `done` cycle, when all of them are final.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRIVE,
    ST_PULSE,
    ST_TURN,
    ST_READ,
    ST_CHECK,
    ST_NEXT,
    ST_RAIL,
    ST_FREAD,
    ST_FCHK,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
  parameter int unsigned CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!last)  cnt_d = cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eprom_byte_judge.sv
module eprom_byte_judge #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] readback,
  output logic          match,
  output logic          stuck
);
  // A cell read as 0 cannot be returned to 1 by further pulses.
  assign match = (target == readback);
  assign stuck = |(target & ~readback);
endmodule

// File: rtl/eprom_fail_latch.sv
module eprom_fail_latch #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit,
  input  logic [AW-1:0] addr,
  output logic          flag,
  output logic [AW-1:0] flag_addr
);
  logic          flag_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    flag_d = flag;
    addr_d = flag_addr;
    if (clr) begin
      flag_d = 1'b0;
      addr_d = '0;
    end else if (hit && !flag) begin
      flag_d = 1'b1;
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      flag_addr <= '0;
    end else begin
      flag      <= flag_d;
      flag_addr <= addr_d;
    end
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int unsigned AW         = 18,
  parameter int unsigned DW         = 8,
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned PULSE_US   = 100,
  parameter int unsigned MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic [AW-1:0] img_addr,
  input  logic [DW-1:0] img_data,
  output logic [AW-1:0] ep_addr,
  inout  wire  [DW-1:0] ep_dq,
  output logic          ep_ce_n,
  output logic          ep_oe_n,
  output logic          ep_pgm_n,
  output logic          vpp_prog_sel,
  output logic          vcc_boost_sel,
  output logic          rail_verify_sel,
  output logic          prog_fail,
  output logic [AW-1:0] prog_fail_addr,
  output logic          verify_fail,
  output logic [AW-1:0] verify_fail_addr
);
  import eprom_prog_pkg::*;

  localparam int unsigned PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int unsigned PW        = $clog2(MAX_PULSES + 1);
  localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};
  localparam logic [PW-1:0] PLS_MAX   = PW'(MAX_PULSES);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [PW-1:0] pls_q, pls_d;
  logic [DW-1:0] rb_q;
  logic          rb_en;
  logic          pulse_last;
  logic          byte_match, byte_stuck;
  logic          run_clr, pfail_hit, vfail_hit;
  logic          dq_oe;

  eprom_pulse_timer #(.CYC(PULSE_CYC)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_PULSE),
    .last  (pulse_last)
  );

  eprom_byte_judge #(.DW(DW)) judge_i (
    .target   (img_data),
    .readback (rb_q),
    .match    (byte_match),
    .stuck    (byte_stuck)
  );

  eprom_fail_latch #(.AW(AW)) pfail_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (run_clr),
    .hit       (pfail_hit),
    .addr      (addr_q),
    .flag      (prog_fail),
    .flag_addr (prog_fail_addr)
  );

  eprom_fail_latch #(.AW(AW)) vfail_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (run_clr),
    .hit       (vfail_hit),
    .addr      (addr_q),
    .flag      (verify_fail),
    .flag_addr (verify_fail_addr)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    pls_d     = pls_q;
    run_clr   = 1'b0;
    pfail_hit = 1'b0;
    vfail_hit = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        run_clr = 1'b1;
        addr_d  = '0;
        pls_d   = '0;
        state_d = ST_LOAD;
      end
      ST_LOAD:  state_d = (img_data == {DW{1'b1}}) ? ST_NEXT : ST_DRIVE;
      ST_DRIVE: state_d = ST_PULSE;
      ST_PULSE: if (pulse_last) begin
        pls_d   = pls_q + 1'b1;
        state_d = ST_TURN;
      end
      ST_TURN:  state_d = ST_READ;
      ST_READ:  state_d = ST_CHECK;
      ST_CHECK: begin
        if (byte_match) begin
          state_d = ST_NEXT;
        end else if (byte_stuck || pls_q == PLS_MAX) begin
          pfail_hit = 1'b1;
          state_d   = ST_NEXT;
        end else begin
          state_d = ST_DRIVE;
        end
      end
      ST_NEXT: begin
        pls_d = '0;
        if (addr_q == LAST_ADDR) begin
          addr_d  = '0;
          state_d = ST_RAIL;
        end else begin
          addr_d  = addr_q + 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_RAIL:  state_d = ST_FREAD;
      ST_FREAD: state_d = ST_FCHK;
      ST_FCHK: begin
        vfail_hit = !byte_match;
        if (addr_q == LAST_ADDR) begin
          state_d = ST_DONE;
        end else begin
          addr_d  = addr_q + 1'b1;
          state_d = ST_FREAD;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign rb_en = (state_q == ST_READ) || (state_q == ST_FREAD);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pls_q   <= '0;
      rb_q    <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pls_q   <= pls_d;
      if (rb_en) rb_q <= ep_dq;
    end
  end

  // Pin and rail decode
  always_comb begin
    ep_ce_n         = 1'b1;
    ep_oe_n         = 1'b1;
    ep_pgm_n        = 1'b1;
    dq_oe           = 1'b0;
    vpp_prog_sel    = 1'b0;
    vcc_boost_sel   = 1'b0;
    rail_verify_sel = 1'b0;
    unique case (state_q)
      ST_LOAD, ST_TURN, ST_CHECK: ep_ce_n = 1'b0;
      ST_DRIVE: begin ep_ce_n = 1'b0; dq_oe = 1'b1; end
      ST_PULSE: begin ep_ce_n = 1'b0; dq_oe = 1'b1; ep_pgm_n = 1'b0; end
      ST_READ, ST_FREAD, ST_FCHK: begin ep_ce_n = 1'b0; ep_oe_n = 1'b0; end
      default: ;
    endcase
    unique case (state_q)
      ST_LOAD, ST_DRIVE, ST_PULSE, ST_TURN, ST_READ, ST_CHECK, ST_NEXT: begin
        vpp_prog_sel  = 1'b1;
        vcc_boost_sel = 1'b1;
      end
      ST_RAIL, ST_FREAD, ST_FCHK: rail_verify_sel = 1'b1;
      default: ;
    endcase
  end

  assign ep_dq    = dq_oe ? img_data : {DW{1'bz}};
  assign img_addr = addr_q;
  assign ep_addr  = addr_q;
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int unsigned PULSE_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic ep_ce_n,
  input logic ep_oe_n,
  input logic ep_pgm_n,
  input logic dq_oe,
  input logic vpp_prog_sel,
  input logic vcc_boost_sel,
  input logic rail_verify_sel,
  input logic done
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (ep_pgm_n) low_cnt <= '0;
    else               low_cnt <= low_cnt + 1;
  end

  assert_pulse_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_pgm_n && low_cnt != 0) |-> (low_cnt == PULSE_CYC));
  assert_pulse_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_pgm_n |-> (low_cnt < PULSE_CYC));
  assert_pulse_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_pgm_n |-> (!ep_ce_n && ep_oe_n && dq_oe && vpp_prog_sel && vcc_boost_sel));
  assert_read_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_oe_n |-> (!dq_oe && ep_pgm_n && !ep_ce_n));
  assert_drive_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |=> ep_oe_n);
  assert_read_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_oe_n |=> !dq_oe);
  assert_rail_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rail_verify_sel |-> (!vcc_boost_sel && !vpp_prog_sel && ep_pgm_n));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .ep_ce_n         (ep_ce_n),
  .ep_oe_n         (ep_oe_n),
  .ep_pgm_n        (ep_pgm_n),
  .dq_oe           (dq_oe),
  .vpp_prog_sel    (vpp_prog_sel),
  .vcc_boost_sel   (vcc_boost_sel),
  .rail_verify_sel (rail_verify_sel),
  .done            (done)
);

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int CLK_HZ = 100_000;
  localparam int PULSE_US = 100;
  localparam int PC = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int MAXP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic [AW-1:0] img_addr, ep_addr, pf_addr, vf_addr;
  logic [DW-1:0] img_data;
  wire  [DW-1:0] dq;
  logic ce_n, oe_n, pgm_n, vpp_sel, boost_sel, vrail_sel, pfail, vfail;

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] tgt [N];
  logic [DW-1:0] init_v [N];
  int            need [N];
  logic [DW-1:0] mem [N];
  int            cnt [N];
  logic          load_req = 1'b0;
  int            leak_addr = -1;
  int            low_cnt = 0;
  logic [DW-1:0] pdata;
  logic          pgm_prev = 1'b1, oe_prev = 1'b1;
  int            v_width = 0, v_pins = 0, v_read = 0, v_gap = 0, v_rail = 0;
  int            done_cnt = 0;

  assign img_data = tgt[img_addr];
  logic [DW-1:0] rd_val;
  assign rd_val = (vrail_sel && leak_addr == int'(ep_addr)) ? (mem[ep_addr] ^ 8'h10) : mem[ep_addr];
  assign dq = (!ce_n && !oe_n && pgm_n) ? rd_val : {DW{1'bz}};

  eprom_prog_seq #(.AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US),
                   .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .img_addr(img_addr), .img_data(img_data), .ep_addr(ep_addr), .ep_dq(dq),
    .ep_ce_n(ce_n), .ep_oe_n(oe_n), .ep_pgm_n(pgm_n),
    .vpp_prog_sel(vpp_sel), .vcc_boost_sel(boost_sel), .rail_verify_sel(vrail_sel),
    .prog_fail(pfail), .prog_fail_addr(pf_addr),
    .verify_fail(vfail), .verify_fail_addr(vf_addr));

  // Memory model and pin monitor
  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < N; i++) begin
        mem[i] <= init_v[i];
        cnt[i] <= 0;
      end
      low_cnt <= 0;
    end else if (rst_n) begin
      if (done) done_cnt <= done_cnt + 1;
      if (!pgm_n) begin
        low_cnt <= low_cnt + 1;
        pdata   <= dq;
        if (ce_n || !oe_n || !vpp_sel || !boost_sel || vrail_sel || dq !== tgt[ep_addr])
          v_pins <= v_pins + 1;
        if (!pgm_prev || !oe_prev) ; else if (!oe_prev) v_gap <= v_gap + 1;
        if (pgm_prev && !oe_prev) v_gap <= v_gap + 1;
      end else if (low_cnt != 0) begin
        if (low_cnt != PC) v_width <= v_width + 1;
        if (!oe_n) v_gap <= v_gap + 1;
        cnt[ep_addr] <= cnt[ep_addr] + 1;
        if (cnt[ep_addr] + 1 >= need[ep_addr]) mem[ep_addr] <= mem[ep_addr] & pdata;
        low_cnt <= 0;
      end
      if (!oe_n && boost_sel && (!vpp_sel || ce_n || !pgm_n)) v_read <= v_read + 1;
      if (!oe_n && !boost_sel && (!vrail_sel || vpp_sel)) v_rail <= v_rail + 1;
      if (vrail_sel && boost_sel) v_rail <= v_rail + 1;
      pgm_prev <= pgm_n;
      oe_prev  <= oe_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 clean, 1 pulse limit at 5, 2 stuck bit at 3, 3 verify leak at 6
  task automatic run_case(input int mode);
    int exp_p [N];
    int exp_cyc, c, exp_pf, exp_vf, exp_pfa, exp_vfa, d0;
    leak_addr = (mode == 3) ? 6 : -1;
    exp_cyc = 1 + 2 * N;
    exp_pf = 0; exp_vf = 0; exp_pfa = 0; exp_vfa = 0;
    for (int a = 0; a < N; a++) begin
      tgt[a]    = (a == 2) ? 8'hFF : (8'h5A ^ 8'(a * 8'h1D));
      init_v[a] = 8'hFF;
      need[a]   = (a % 3) + 1;
    end
    if (mode == 1) need[5] = MAXP + 2;
    if (mode == 2) init_v[3] = 8'hFE;
    for (int a = 0; a < N; a++) begin
      if (tgt[a] == 8'hFF) exp_p[a] = 0;
      else if (mode == 2 && a == 3) exp_p[a] = 1;
      else exp_p[a] = (need[a] > MAXP) ? MAXP : need[a];
      exp_cyc += (exp_p[a] == 0) ? 2 : 2 + exp_p[a] * (PC + 4);
    end
    if (mode == 1) begin exp_pf = 1; exp_pfa = 5; exp_vf = 1; exp_vfa = 5; end
    if (mode == 2) begin exp_pf = 1; exp_pfa = 3; exp_vf = 1; exp_vfa = 3; end
    if (mode == 3) begin exp_vf = 1; exp_vfa = 6; end

    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    v_width = 0; v_pins = 0; v_read = 0; v_gap = 0; v_rail = 0;
    d0 = done_cnt;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    c = 1;
    // R10: flags cleared by accepted start
    chk(pfail == 0 && vfail == 0, "R10 flags cleared at start", int'(pfail) + int'(vfail), 0);
    while (!done) begin
      @(negedge clk); c++;
    end
    chk(c == exp_cyc + 1, "R10 done cycle", c, exp_cyc + 1);
    chk(pfail == exp_pf, "R5/R6 prog_fail", pfail, exp_pf);
    if (exp_pf) chk(pf_addr == exp_pfa, "R5/R6 prog_fail_addr", pf_addr, exp_pfa);
    chk(vfail == exp_vf, "R9 verify_fail", vfail, exp_vf);
    if (exp_vf) chk(vf_addr == exp_vfa, "R9 verify_fail_addr", vf_addr, exp_vfa);
    for (int a = 0; a < N; a++) begin
      if (a == 2) chk(cnt[a] == 0, "R7 skipped byte pulses", cnt[a], 0);
      else if (mode == 2 && a == 3) chk(cnt[a] == 1, "R6 stuck byte pulses", cnt[a], 1);
      else if (mode == 1 && a == 5) chk(cnt[a] == MAXP, "R5 limit pulses", cnt[a], MAXP);
      else chk(cnt[a] == exp_p[a], "R4 pulses per address", cnt[a], exp_p[a]);
    end
    @(negedge clk);
    chk(!done, "R10 done single cycle", done, 0);
    chk(done_cnt - d0 == 1, "R10 done count", done_cnt - d0, 1);
    chk(pfail == exp_pf && vfail == exp_vf, "R10 flags held after done",
        int'(pfail) + int'(vfail), exp_pf + exp_vf);
    chk(v_width == 0, "R1 pulse width", v_width, 0);
    chk(v_pins == 0, "R2 pulse pin levels", v_pins, 0);
    chk(v_read == 0, "R3 read-back pin levels", v_read, 0);
    chk(v_gap == 0, "R8 idle gap around pulse", v_gap, 0);
    chk(v_rail == 0, "R9 rail selects", v_rail, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < N; a++) begin
      tgt[a] = 8'hFF; init_v[a] = 8'hFF; need[a] = 1;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ce_n && oe_n && pgm_n, "R11 control pins idle", {ce_n, oe_n, pgm_n}, 7);
    chk(!done && !vpp_sel && !boost_sel && !vrail_sel && !pfail && !vfail,
        "R11 outputs low", {done, vpp_sel, boost_sel, vrail_sel, pfail, vfail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(1);
    run_case(0);
    run_case(2);
    run_case(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100_000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule